// File: doc/BRIEF.md
# Prioritised Dual-Output Interrupt Controller

The block collects 64 level-sensitive interrupt sources and drives two requests: a normal request and a fast request. Each source has a pending bit, an enable bit and a type bit. A type bit of 1 routes the source to the fast request and 0 routes it to the normal request. Each source also has a 4-bit priority. A 5-bit threshold gates the normal request. Its all-ones value switches the gating off.

Software uses a single-cycle register port with byte addresses, a write strobe and a read strobe. Read data is combinational and valid in any cycle in which the read strobe is high. Two vector registers return the winning source and acknowledge it. The normal one picks the highest priority and breaks ties toward the higher source number. The fast one picks the lowest-numbered source. Acknowledging a source clears its pending bit on the clock edge that ends the read cycle. A source whose input stays high then stays cleared until its input falls and rises again. Per-source vector-address writes in byte range 0x100–0x2FC are accepted and discarded.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising source input sets its pending bit and a falling one clears it, both at the next clock edge. A level that is merely held changes nothing, so an acknowledged source stays clear while its input stays high.
- R2: Enable and type are 64-bit maps. Word 2 sets one enable bit and word 3 clears one, both selected by write data bits 5:0, and both words read as 0. Words 4/5 hold enable bits 63:32 and 31:0, and words 6/7 hold type bits 63:32 and 31:0.
- R3: `fast_irq_o` is high one cycle after any source is pending, enabled and of fast type, and low one cycle after none is.
- R4: `norm_irq_o` follows a one-cycle delay. It is low when no enabled normal source is pending. When the threshold is 0x1F it is high if any such source is pending. Otherwise it is high only if such a source has a priority strictly above the threshold.
- R5: The priority of source n sits in bits 4*(n%8)+3 : 4*(n%8) of priority word n/8. Priority word k is at word address 15-k, so word 8 holds sources 56–63.
- R6: A read of word 16 returns (source<<16)|priority for the pending, enabled, normal source with the highest priority, with ties going to the higher source number. That source's pending bit is cleared. The read returns 0xFFFFFFFF when no source qualifies.
- R7: A read of word 17 returns the number of the lowest-numbered pending, enabled fast source and clears its pending bit. It returns 0xFFFFFFFF when none qualifies.
- R8: Writes to words 21/20 load pending bits 31:0 and 63:32 directly, and both words read as 0. Words 19/18 return the raw pending bits 31:0 and 63:32. Words 23/22 return pending AND enabled AND normal, and words 25/24 return pending AND enabled AND fast, each pair low/high half.
- R9: Writes to words 16–19 and 22–25 change nothing, and neither does any write in byte range 0x100–0x2FC.
- R10: A read of word 0x40 returns 4, and a read of any other unmapped word returns 0.
- R11: After reset, pending, enable, type, control and all priorities are 0, the threshold (word 1, bits 4:0) is 0x1F and both requests are low.
- R12: Control (word 0) keeps only bits 0 (abort enable), 2 (normal disable), 3 (fast disable), 4 (normal bias), 5 (fast bias) and 6 (vector mode). Bit 1 is an abort flag that software cannot set and that is write-1-to-clear while abort enable is set. Writing all ones reads back 0x7D.
- R13: A vector word addressed without the read strobe clears no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level-sensitive interrupt source inputs |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe; vector side effects occur only while it is high |
| bus_rdata_o | output | 32 | Read data, valid while `bus_rd_i` is high, 0 otherwise |
| norm_irq_o | output | 1 | Registered normal interrupt request |
| fast_irq_o | output | 1 | Registered fast interrupt request |

## Verification
The assertions check the following on every cycle:
- the one-cycle relation between the active maps and both requests, including the open-threshold and high-threshold cases;
- that each search winner is an active source, and that the fast winner has no lower-numbered active source;
- that an acknowledged source is clear on the next cycle.

Other behaviour shows up only through the bench's scenarios:
- that equal priorities go to the higher source number;
- the reversed order of the priority words;
- that a held input does not re-arm a source;
- that force, ignored writes and unmapped reads behave as stated.

The bench compares every read and both requests with a model built from the requirements.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int SRC_COUNT    = 64;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 12;
  localparam int PRIO_W       = 4;
  localparam int MASK_W       = 5;
  localparam int IDX_W        = $clog2(SRC_COUNT);
  localparam int HALF         = SRC_COUNT / 2;
  localparam int NIB_PER_WORD = DATA_W / PRIO_W;
  localparam int PRIO_WORDS   = SRC_COUNT / NIB_PER_WORD;
  localparam int WOFF_W       = ADDR_W - 2;

  localparam logic [MASK_W-1:0] MASK_OPEN = '1;

  // word offsets
  localparam int OFF_CTL     = 0;
  localparam int OFF_MASK    = 1;
  localparam int OFF_EN_NUM  = 2;
  localparam int OFF_DIS_NUM = 3;
  localparam int OFF_EN_HI   = 4;
  localparam int OFF_EN_LO   = 5;
  localparam int OFF_TYP_HI  = 6;
  localparam int OFF_TYP_LO  = 7;
  localparam int OFF_PR_LO   = 8;
  localparam int OFF_PR_HI   = 15;
  localparam int OFF_NVEC    = 16;
  localparam int OFF_FVEC    = 17;
  localparam int OFF_RAW_HI  = 18;
  localparam int OFF_RAW_LO  = 19;
  localparam int OFF_FRC_HI  = 20;
  localparam int OFF_FRC_LO  = 21;
  localparam int OFF_NACT_HI = 22;
  localparam int OFF_NACT_LO = 23;
  localparam int OFF_FACT_HI = 24;
  localparam int OFF_FACT_LO = 25;
  localparam int OFF_MAGIC   = 64;
  localparam logic [DATA_W-1:0] MAGIC_VAL = 4;
  localparam logic [DATA_W-1:0] NONE_VAL  = '1;

  // control bit positions
  localparam int CTL_ABT_EN   = 0;
  localparam int CTL_ABT_FLAG = 1;
  localparam int CTL_NDIS     = 2;
  localparam int CTL_FDIS     = 3;
  localparam int CTL_NBIAS    = 4;
  localparam int CTL_FBIAS    = 5;
  localparam int CTL_VMODE    = 6;
  localparam logic [DATA_W-1:0] CTL_KEEP =
    (DATA_W'(1) << CTL_ABT_EN) | (DATA_W'(1) << CTL_NDIS) |
    (DATA_W'(1) << CTL_FDIS)   | (DATA_W'(1) << CTL_NBIAS) |
    (DATA_W'(1) << CTL_FBIAS)  | (DATA_W'(1) << CTL_VMODE);

  typedef struct packed {
    logic              found;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] prio;
  } win_t;

  function automatic logic [PRIO_W-1:0] prio_of(
    input logic [SRC_COUNT*PRIO_W-1:0] flat, input logic [IDX_W-1:0] idx);
    return flat[idx*PRIO_W +: PRIO_W];
  endfunction

  // normal request rule: open threshold, otherwise strict comparison
  function automatic logic norm_fire(
    input logic [SRC_COUNT-1:0] act, input logic [SRC_COUNT*PRIO_W-1:0] flat,
    input logic [MASK_W-1:0] mask);
    logic hit;
    hit = 1'b0;
    if (act != '0) begin
      if (mask == MASK_OPEN) hit = 1'b1;
      else begin
        for (int i = 0; i < SRC_COUNT; i++)
          if (act[i] && ({1'b0, flat[i*PRIO_W +: PRIO_W]} > mask)) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  function automatic logic [DATA_W-1:0] norm_vec_word(input win_t w);
    if (!w.found) return NONE_VAL;
    return (DATA_W'(w.idx) << 16) | DATA_W'(w.prio);
  endfunction

  function automatic logic [DATA_W-1:0] fast_vec_word(input win_t w);
    if (!w.found) return NONE_VAL;
    return DATA_W'(w.idx);
  endfunction
endpackage

// File: rtl/pic_src_state.sv
module pic_src_state
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] src_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 en_set_i,
  input  logic                 en_clr_i,
  input  logic                 en_hi_wr_i,
  input  logic                 en_lo_wr_i,
  input  logic                 typ_hi_wr_i,
  input  logic                 typ_lo_wr_i,
  input  logic                 frc_hi_wr_i,
  input  logic                 frc_lo_wr_i,
  input  logic                 ack_norm_i,
  input  logic [IDX_W-1:0]     ack_norm_idx_i,
  input  logic                 ack_fast_i,
  input  logic [IDX_W-1:0]     ack_fast_idx_i,
  output logic [SRC_COUNT-1:0] pend_o,
  output logic [SRC_COUNT-1:0] en_o,
  output logic [SRC_COUNT-1:0] typ_o
);
  logic [SRC_COUNT-1:0] src_q, pend_q, pend_nxt, en_q, typ_q;
  logic [SRC_COUNT-1:0] src_rise, src_fall;
  logic [IDX_W-1:0]     num_sel;
  logic                 frc_any;

  assign src_rise = src_i & ~src_q;
  assign src_fall = ~src_i & src_q;
  assign num_sel  = wdata_i[IDX_W-1:0];
  assign frc_any  = frc_hi_wr_i | frc_lo_wr_i;

  // per-source pending update: force > acknowledge > input edge
  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
    localparam bit IS_HI = (i >= HALF);
    logic frc_hit, ack_hit;
    assign frc_hit = IS_HI ? frc_hi_wr_i : frc_lo_wr_i;
    assign ack_hit = (ack_norm_i && ack_norm_idx_i == IDX_W'(i)) ||
                     (ack_fast_i && ack_fast_idx_i == IDX_W'(i));
    assign pend_nxt[i] = frc_hit  ? wdata_i[i % HALF] :
                         ack_hit  ? 1'b0 :
                         src_rise[i] ? 1'b1 :
                         src_fall[i] ? 1'b0 : pend_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      typ_q <= '0;
    end else begin
      if (en_set_i)    en_q[num_sel] <= 1'b1;
      if (en_clr_i)    en_q[num_sel] <= 1'b0;
      if (en_hi_wr_i)  en_q[SRC_COUNT-1:HALF] <= wdata_i[HALF-1:0];
      if (en_lo_wr_i)  en_q[HALF-1:0] <= wdata_i[HALF-1:0];
      if (typ_hi_wr_i) typ_q[SRC_COUNT-1:HALF] <= wdata_i[HALF-1:0];
      if (typ_lo_wr_i) typ_q[HALF-1:0] <= wdata_i[HALF-1:0];
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign typ_o  = typ_q;

  // acknowledged source is clear on the next cycle
  p_norm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_norm_i && !frc_any) |=> !pend_q[$past(ack_norm_idx_i)]);
  p_fast_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fast_i && !frc_any) |=> !pend_q[$past(ack_fast_idx_i)]);
  // a held input level never sets pending on its own
  p_held_no_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frc_any && src_q == src_i && !pend_q[0]) |=> !pend_q[0]);
endmodule

// File: rtl/pic_prio_store.sv
module pic_prio_store
  import pic_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PRIO_WORDS-1:0]         word_we_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [SRC_COUNT*PRIO_W-1:0]   prio_flat_o
);
  // word k holds sources 8k..8k+7, nibble 0 in the low bits
  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           word_q <= '0;
      else if (word_we_i[w]) word_q <= wdata_i;
    end
    assign prio_flat_o[w*DATA_W +: DATA_W] = word_q;
  end

  p_one_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we_i));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SRC_COUNT-1:0]        act_norm_i,
  input  logic [SRC_COUNT-1:0]        act_fast_i,
  input  logic [SRC_COUNT*PRIO_W-1:0] prio_flat_i,
  input  logic [MASK_W-1:0]           mask_i,
  output win_t                        norm_win_o,
  output win_t                        fast_win_o,
  output logic                        norm_irq_o,
  output logic                        fast_irq_o
);
  localparam logic [SRC_COUNT-1:0] ONE = SRC_COUNT'(1);
  win_t nw, fw;
  logic norm_irq_q, fast_irq_q;

  // ascending scan with >= : equal priority goes to the higher number
  always_comb begin
    nw = '0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      if (act_norm_i[i] &&
          (!nw.found || prio_of(prio_flat_i, IDX_W'(i)) >= nw.prio)) begin
        nw.found = 1'b1;
        nw.idx   = IDX_W'(i);
        nw.prio  = prio_of(prio_flat_i, IDX_W'(i));
      end
    end
  end

  // descending scan: the last hit is the lowest number
  always_comb begin
    fw = '0;
    for (int i = SRC_COUNT - 1; i >= 0; i--) begin
      if (act_fast_i[i]) begin
        fw.found = 1'b1;
        fw.idx   = IDX_W'(i);
        fw.prio  = prio_of(prio_flat_i, IDX_W'(i));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_irq_q <= 1'b0;
      fast_irq_q <= 1'b0;
    end else begin
      norm_irq_q <= norm_fire(act_norm_i, prio_flat_i, mask_i);
      fast_irq_q <= |act_fast_i;
    end
  end

  assign norm_win_o = nw;
  assign fast_win_o = fw;
  assign norm_irq_o = norm_irq_q;
  assign fast_irq_o = fast_irq_q;

  p_fast_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fast_i != '0) |=> fast_irq_o);
  p_fast_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fast_i == '0) |=> !fast_irq_o);
  p_norm_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_norm_i == '0) |=> !norm_irq_o);
  p_norm_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_norm_i != '0 && mask_i == MASK_OPEN) |=> norm_irq_o);
  p_norm_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nw.found && {1'b0, nw.prio} > mask_i) |=> norm_irq_o);
  p_norm_high_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i != MASK_OPEN && mask_i[MASK_W-1]) |=> !norm_irq_o);
  p_norm_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nw.found |-> act_norm_i[nw.idx]);
  p_norm_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nw.found |-> (act_norm_i == '0));
  p_fast_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fw.found |-> (act_fast_i[fw.idx] &&
                  ((act_fast_i & ((ONE << fw.idx) - ONE)) == '0)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] src_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  input  logic                 bus_rd_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 norm_irq_o,
  output logic                 fast_irq_o
);
  logic [WOFF_W-1:0]           woff;
  logic [SRC_COUNT-1:0]        pend, en, typ, act_norm, act_fast;
  logic [SRC_COUNT*PRIO_W-1:0] prio_flat;
  logic [PRIO_WORDS-1:0]       prio_we;
  logic [MASK_W-1:0]           mask_q;
  logic [DATA_W-1:0]           ctl_q, rmux;
  win_t                        norm_win, fast_win;
  logic                        ack_norm, ack_fast;
  logic                        unused_addr_lsb;

  assign woff            = bus_addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr_i[1:0];

  function automatic logic wr_at(input int off);
    return bus_wr_i && (woff == WOFF_W'(off));
  endfunction

  // word k of the priority store sits at word address 15-k
  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_pwe
    assign prio_we[w] = wr_at(OFF_PR_HI - w);
  end

  assign act_norm = pend & en & ~typ;
  assign act_fast = pend & en & typ;
  assign ack_norm = bus_rd_i && woff == WOFF_W'(OFF_NVEC) && norm_win.found;
  assign ack_fast = bus_rd_i && woff == WOFF_W'(OFF_FVEC) && fast_win.found;

  pic_src_state u_state (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wdata_i(bus_wdata_i),
    .en_set_i(wr_at(OFF_EN_NUM)), .en_clr_i(wr_at(OFF_DIS_NUM)),
    .en_hi_wr_i(wr_at(OFF_EN_HI)), .en_lo_wr_i(wr_at(OFF_EN_LO)),
    .typ_hi_wr_i(wr_at(OFF_TYP_HI)), .typ_lo_wr_i(wr_at(OFF_TYP_LO)),
    .frc_hi_wr_i(wr_at(OFF_FRC_HI)), .frc_lo_wr_i(wr_at(OFF_FRC_LO)),
    .ack_norm_i(ack_norm), .ack_norm_idx_i(norm_win.idx),
    .ack_fast_i(ack_fast), .ack_fast_idx_i(fast_win.idx),
    .pend_o(pend), .en_o(en), .typ_o(typ)
  );

  pic_prio_store u_prio (
    .clk(clk), .rst_n(rst_n), .word_we_i(prio_we), .wdata_i(bus_wdata_i),
    .prio_flat_o(prio_flat)
  );

  pic_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .act_norm_i(act_norm), .act_fast_i(act_fast),
    .prio_flat_i(prio_flat), .mask_i(mask_q),
    .norm_win_o(norm_win), .fast_win_o(fast_win),
    .norm_irq_o(norm_irq_o), .fast_irq_o(fast_irq_o)
  );

  // control and threshold registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mask_q <= MASK_OPEN;
    end else begin
      if (wr_at(OFF_CTL)) begin
        ctl_q <= bus_wdata_i & CTL_KEEP;
        ctl_q[CTL_ABT_FLAG] <= ctl_q[CTL_ABT_FLAG] &
          ~(bus_wdata_i[CTL_ABT_FLAG] & bus_wdata_i[CTL_ABT_EN]);
      end
      if (wr_at(OFF_MASK)) mask_q <= bus_wdata_i[MASK_W-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    case (int'(woff))
      OFF_CTL:     rmux = ctl_q;
      OFF_MASK:    rmux = DATA_W'(mask_q);
      OFF_EN_HI:   rmux = en[SRC_COUNT-1:HALF];
      OFF_EN_LO:   rmux = en[HALF-1:0];
      OFF_TYP_HI:  rmux = typ[SRC_COUNT-1:HALF];
      OFF_TYP_LO:  rmux = typ[HALF-1:0];
      OFF_NVEC:    rmux = norm_vec_word(norm_win);
      OFF_FVEC:    rmux = fast_vec_word(fast_win);
      OFF_RAW_HI:  rmux = pend[SRC_COUNT-1:HALF];
      OFF_RAW_LO:  rmux = pend[HALF-1:0];
      OFF_NACT_HI: rmux = act_norm[SRC_COUNT-1:HALF];
      OFF_NACT_LO: rmux = act_norm[HALF-1:0];
      OFF_FACT_HI: rmux = act_fast[SRC_COUNT-1:HALF];
      OFF_FACT_LO: rmux = act_fast[HALF-1:0];
      OFF_MAGIC:   rmux = MAGIC_VAL;
      default: begin
        if (int'(woff) >= OFF_PR_LO && int'(woff) <= OFF_PR_HI)
          rmux = prio_flat[(OFF_PR_HI - int'(woff))*DATA_W +: DATA_W];
      end
    endcase
  end

  assign bus_rdata_o = bus_rd_i ? rmux : '0;

  // reset values seen on the first cycle out of reset
  p_reset_vals_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == MASK_OPEN && ctl_q == '0 && pend == '0));
  p_ctl_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~CTL_KEEP) == '0);
  p_ack_needs_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_norm || ack_fast) |-> bus_rd_i);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic [11:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        norm_irq_o, fast_irq_o;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .bus_rd_i(bus_rd_i),
    .bus_rdata_o(bus_rdata_o), .norm_irq_o(norm_irq_o), .fast_irq_o(fast_irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [63:0] m_pend = '0, m_en = '0, m_typ = '0, m_srcq = '0;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_mask = 5'h1F;
  logic [31:0] m_ctl = '0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] prio_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) r[k*4 +: 4] = m_pr[w*8 + k];
    return r;
  endfunction

  function automatic int norm_pick();
    int best = -1;
    logic [63:0] a = m_pend & m_en & ~m_typ;
    for (int i = 63; i >= 0; i--)
      if (a[i] && (best < 0 || m_pr[i] > m_pr[best])) best = i;
    return best;
  endfunction

  function automatic int fast_pick();
    logic [63:0] a = m_pend & m_en & m_typ;
    for (int i = 0; i < 64; i++) if (a[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_norm_irq();
    logic [63:0] a = m_pend & m_en & ~m_typ;
    int top = -1;
    if (a == 0) return 1'b0;
    if (m_mask == 5'h1F) return 1'b1;
    for (int i = 0; i < 64; i++) if (a[i] && int'(m_pr[i]) > top) top = int'(m_pr[i]);
    return top > int'(m_mask);
  endfunction

  function automatic logic [31:0] exp_read(input int off);
    logic [63:0] na = m_pend & m_en & ~m_typ;
    logic [63:0] fa = m_pend & m_en & m_typ;
    int p;
    case (off)
      0: return m_ctl;
      1: return {27'd0, m_mask};
      4: return m_en[63:32];   5: return m_en[31:0];
      6: return m_typ[63:32];  7: return m_typ[31:0];
      16: begin p = norm_pick(); return (p < 0) ? 32'hFFFF_FFFF : ((p << 16) | int'(m_pr[p])); end
      17: begin p = fast_pick(); return (p < 0) ? 32'hFFFF_FFFF : p; end
      18: return m_pend[63:32]; 19: return m_pend[31:0];
      22: return na[63:32];     23: return na[31:0];
      24: return fa[63:32];     25: return fa[31:0];
      64: return 32'd4;
      default: if (off >= 8 && off <= 15) return prio_word(15 - off);
    endcase
    return 32'd0;
  endfunction

  function automatic string req_for(input int off);
    if (off == 16) return "R6";
    if (off == 17) return "R7";
    if (off >= 18) return "R8";
    if (off >= 8)  return "R5";
    if (off >= 2)  return "R2";
    if (off == 1)  return "R4";
    return "R12";
  endfunction

  task automatic m_write(input logic [11:0] addr, input logic [31:0] d);
    int off = int'(addr[11:2]);
    case (off)
      0: m_ctl = d & 32'h7D;
      1: m_mask = d[4:0];
      2: m_en[d[5:0]] = 1'b1;
      3: m_en[d[5:0]] = 1'b0;
      4: m_en[63:32] = d;  5: m_en[31:0] = d;
      6: m_typ[63:32] = d; 7: m_typ[31:0] = d;
      20: m_pend[63:32] = d; 21: m_pend[31:0] = d;
      default: if (off >= 8 && off <= 15)
        for (int k = 0; k < 8; k++) m_pr[(15 - off)*8 + k] = d[k*4 +: 4];
    endcase
  endtask

  task automatic do_write_addr(input logic [11:0] addr, input logic [31:0] d);
    @(negedge clk);
    bus_addr_i = addr; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk);
    m_write(addr, d);
    #1 bus_wr_i = 1'b0;
  endtask

  task automatic do_write(input int off, input logic [31:0] d);
    do_write_addr(12'(off << 2), d);
  endtask

  task automatic do_read(input int off, output logic [31:0] got);
    int p;
    @(negedge clk);
    bus_addr_i = 12'(off << 2); bus_rd_i = 1'b1;
    #1 got = bus_rdata_o;
    chk(req_for(off), got, exp_read(off));
    @(posedge clk);
    if (off == 16) begin p = norm_pick(); if (p >= 0) m_pend[p] = 1'b0; end
    if (off == 17) begin p = fast_pick(); if (p >= 0) m_pend[p] = 1'b0; end
    #1 bus_rd_i = 1'b0;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src_i = v;
    @(posedge clk);
    m_pend = (m_pend | (v & ~m_srcq)) & ~(~v & m_srcq);
    m_srcq = v;
  endtask

  task automatic settle_chk(input string req);
    @(posedge clk);
    #1;
    chk({req, " norm"}, {31'd0, norm_irq_o}, {31'd0, exp_norm_irq()});
    chk({req, " fast"}, {31'd0, fast_irq_o}, {31'd0, ((m_pend & m_en & m_typ) != 0)});
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] sv;
    for (int i = 0; i < 64; i++) m_pr[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    settle_chk("R11");
    do_read(1, r); chk("R11 mask", r, 32'h1F);
    do_read(0, r); chk("R11 ctl", r, 32'h0);
    do_read(19, r); chk("R11 pending", r, 32'h0);

    // R6 tie at equal priority, R5 layout
    do_write(2, 10); do_write(2, 20);
    do_write(14, 32'h0000_0700);  // word 1, nibble 2 -> source 10
    do_write(13, 32'h0007_0000);  // word 2, nibble 4 -> source 20
    sv = '0; sv[10] = 1; sv[20] = 1;
    set_src(sv);
    settle_chk("R4");
    chk("R4 open threshold", {31'd0, norm_irq_o}, 32'd1);
    do_read(16, r); chk("R6 tie high", r, 32'h0014_0007);
    do_read(16, r); chk("R6 second", r, 32'h000A_0007);
    do_read(16, r); chk("R6 none", r, 32'hFFFF_FFFF);
    settle_chk("R6");
    // R1 held level does not re-arm
    repeat (3) @(posedge clk);
    do_read(19, r); chk("R1 held stays clear", r, 32'h0);
    sv[10] = 0; set_src(sv);
    sv[10] = 1; set_src(sv);
    do_read(19, r); chk("R1 re-rise sets", r, 32'h0000_0400);

    // R4 threshold
    do_write(1, 7);  settle_chk("R4"); chk("R4 equal blocked", {31'd0, norm_irq_o}, 32'd0);
    do_write(1, 6);  settle_chk("R4"); chk("R4 above passes", {31'd0, norm_irq_o}, 32'd1);
    do_write(1, 20); settle_chk("R4"); chk("R4 high mask", {31'd0, norm_irq_o}, 32'd0);
    do_write(14, 0); do_write(1, 31); settle_chk("R4");
    chk("R4 open prio0", {31'd0, norm_irq_o}, 32'd1);
    do_write(1, 0);  settle_chk("R4"); chk("R4 prio0 vs 0", {31'd0, norm_irq_o}, 32'd0);
    do_write(1, 31);

    // R7 fast lowest first
    do_write(2, 3); do_write(2, 40);
    do_write(7, 32'h8); do_write(6, 32'h100);
    sv[3] = 1; sv[40] = 1; set_src(sv);
    settle_chk("R3"); chk("R3 fast up", {31'd0, fast_irq_o}, 32'd1);
    do_read(17, r); chk("R7 lowest", r, 32'd3);
    do_read(17, r); chk("R7 next", r, 32'd40);
    do_read(17, r); chk("R7 none", r, 32'hFFFF_FFFF);
    settle_chk("R3"); chk("R3 fast down", {31'd0, fast_irq_o}, 32'd0);

    // R8 force
    do_write(21, 32'h1);
    do_read(19, r); chk("R8 force lo", r, 32'h1);
    do_read(20, r); chk("R8 force reads 0", r, 32'h0);
    do_read(21, r); chk("R8 force reads 0", r, 32'h0);
    // R13 address without strobe
    do_write(2, 0);
    @(negedge clk); bus_addr_i = 12'(16 << 2);
    repeat (2) @(posedge clk);
    do_read(19, r); chk("R13 no strobe no clear", r, 32'h1);
    do_read(16, r); chk("R6 source 0", r, 32'h0000_0000);
    do_read(19, r); chk("R6 cleared", r, 32'h0);

    // R9 ignored writes, R10 constants
    do_write(21, 32'h55); do_write(20, 32'hA);
    do_write(16, '1); do_write(17, '1); do_write(18, 0); do_write(19, 0);
    do_write(22, '1); do_write(25, '1);
    do_write_addr(12'h100, '1); do_write_addr(12'h2FC, '1);
    do_read(19, r); chk("R9 pending lo kept", r, 32'h55);
    do_read(18, r); chk("R9 pending hi kept", r, 32'hA);
    do_read(5, r);  chk("R9 enable kept", r, exp_read(5));
    do_read(64, r); chk("R10 magic", r, 32'd4);
    do_read(30, r); chk("R10 unmapped", r, 32'd0);
    do_read(2, r);  chk("R2 num reads 0", r, 32'd0);
    do_read(3, r);  chk("R2 num reads 0", r, 32'd0);

    // R12 control
    do_write(0, '1); do_read(0, r); chk("R12 kept bits", r, 32'h7D);
    do_write(0, 0);  do_read(0, r); chk("R12 cleared", r, 32'h0);

    // R5 reversed word order: word address 8 -> sources 56..63
    do_write(21, 0); do_write(20, 0);
    do_write(2, 63); do_write(8, 32'hA000_0000);
    sv[63] = 1; set_src(sv);
    do_read(16, r); chk("R5 source 63 prio", r, 32'h003F_000A);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 10);
      int off;
      if (op < 3) begin
        sv = sv ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
        set_src(sv);
      end else if (op < 6) begin
        case ($urandom % 12)
          0: do_write(1, ($urandom % 4 == 0) ? 32'h1F : ($urandom % 32));
          1: do_write(2, $urandom); 2: do_write(3, $urandom);
          3: do_write(4, $urandom); 4: do_write(5, $urandom);
          5: do_write(6, $urandom); 6: do_write(7, $urandom);
          7: do_write(20, $urandom & $urandom); 8: do_write(21, $urandom & $urandom);
          9: do_write(0, $urandom);
          default: do_write(8 + int'($urandom % 8), $urandom);
        endcase
      end else if (op < 9) begin
        off = ($urandom % 3 == 0) ? 16 : (($urandom % 3 == 0) ? 17 : int'($urandom % 26));
        do_read(off, r);
      end
      settle_chk("R4/R3 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule